// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This block is the power-management state machine of a small system-on-chip. Software writes a mode request (run, idle or sleep). The controller moves the chip into that mode and drives the enables for the CPU clock, the peripheral clocks, the main oscillator, the internal RC oscillator (its output and its power separately), the RTC oscillator, the PLL (power and connect), the clock-divider reset and the flash. The analog parts appear only as enable and ready signals.

Idle stops only the processor clock. Any enabled interrupt brings the CPU straight back. Sleep stops the main oscillator and every internal clock, and shuts off and disconnects the PLL. Only interrupts in a separate wake mask can end it. A down-counting oscillator-stabilisation timer withholds the CPU clock after any reset and after every sleep wake, until the count has expired and the oscillator reports ready. A status field records which low-power mode was left last.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset is released, `cpu_clk_en_o` stays 0 while the wake-up count runs and while `osc_ready_i` is 0. With `osc_ready_i` held at 1 it rises exactly WAKE_CYCLES+1 clock edges after release. With `osc_ready_i` low it rises on the first edge after `osc_ready_i` goes high once the count has expired.
- R2: In run, `cpu_clk_en_o`, `periph_clk_en_o`, `main_osc_en_o` and `irc_out_en_o` are all 1 and `mode_o` reads 2'b00.
- R3: A write with `req_mode_i`=2'b01 in run enters idle on the next edge. In idle the CPU clock is 0, the peripheral clocks and the main oscillator stay 1, and `mode_o` reads 2'b01.
- R4: Idle ends on the first edge at which a bit of `irq_i` is set together with the same bit of `irq_en_i`. The CPU clock returns on that edge with no wake-up count, and `exit_mode_o` becomes 2'b01. Interrupts that are not enabled leave idle unchanged.
- R5: A write with `req_mode_i`=2'b10 in run enters sleep. In sleep the CPU clock, the peripheral clocks, the main oscillator, the RC oscillator output, `pll_en_o` and `pll_connect_o` are 0. `irc_pwr_en_o`, `rtc_osc_en_o`, `flash_en_o` and `div_rst_o` are 1, and `mode_o` reads 2'b10.
- R6: Sleep ends only on a bit of `irq_i` that is also set in `sleep_wake_mask_i`. Interrupts enabled only in `irq_en_i` have no effect in sleep.
- R7: A sleep wake starts the wake-up timer again. The main oscillator turns on at the wake edge. The CPU clock returns WAKE_CYCLES+1 edges after the wake edge (with `osc_ready_i` high). `exit_mode_o` becomes 2'b10.
- R8: Mode requests and PLL configuration writes are ignored outside run. The request code 2'b11 is ignored in run.
- R9: Reset from any mode returns the block to the wake-up count with the CPU clock off. `mode_o` and `exit_mode_o` read 2'b00, and the PLL is off.
- R10: `mode_o` clears to 2'b00 on the edge that ends idle or sleep.
- R11: A configuration write in run sets `pll_en_o` from `cfg_pll_en_i` and `pll_connect_o` from `cfg_pll_en_i & cfg_pll_conn_i`. Both stay 0 after a sleep wake until software writes them again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator-derived clock |
| rst_ni | input | 1 | Asynchronous active-low reset (all reset types) |
| req_wr_i | input | 1 | Mode request write strobe |
| req_mode_i | input | 2 | Requested mode: 00 run, 01 idle, 10 sleep |
| cfg_wr_i | input | 1 | PLL configuration write strobe |
| cfg_pll_en_i | input | 1 | Requested PLL power |
| cfg_pll_conn_i | input | 1 | Requested PLL connect |
| irq_i | input | NIRQ | Interrupt lines |
| irq_en_i | input | NIRQ | Interrupt enables (idle wake) |
| sleep_wake_mask_i | input | NIRQ | Interrupts able to end sleep |
| osc_ready_i | input | 1 | Main oscillator ready |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| periph_clk_en_o | output | 1 | Peripheral clock enable |
| main_osc_en_o | output | 1 | Main oscillator enable |
| irc_out_en_o | output | 1 | RC oscillator output enable |
| irc_pwr_en_o | output | 1 | RC oscillator power enable |
| rtc_osc_en_o | output | 1 | RTC oscillator enable |
| flash_en_o | output | 1 | Flash enable |
| pll_en_o | output | 1 | PLL power enable |
| pll_connect_o | output | 1 | PLL connect |
| div_rst_o | output | 1 | Clock divider reset |
| mode_o | output | 2 | Mode register readback |
| exit_mode_o | output | 2 | Last low-power mode exited |

## Verification
A wrong state register shows at the enable outputs on the edge after it goes wrong. An idle that never ends keeps `cpu_clk_en_o` low after an enabled interrupt. A sleep taken for idle leaves `main_osc_en_o` low. A wrong wake-up counter shows up only as the CPU clock returning one or more edges early or late, so the bench counts the exact edge of release after reset and after sleep wake. A lost or stale PLL setting shows at `pll_connect_o` on the first sample after a sleep wake.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'b00,
        MODE_IDLE  = 2'b01,
        MODE_SLEEP = 2'b10
    } pwr_mode_e;

    typedef enum logic [1:0] {
        ST_WARM,
        ST_RUN,
        ST_IDLE,
        ST_SLEEP
    } pwr_state_e;

    typedef struct packed {
        pwr_state_e state;
        pwr_mode_e  mode;
        pwr_mode_e  exited;
        logic       pll_en;
        logic       pll_conn;
    } pwr_ctx_t;

    typedef struct packed {
        logic cpu;
        logic periph;
        logic osc;
        logic irc_out;
        logic div_rst;
    } clk_ctl_t;

endpackage

// File: rtl/pwr_wake_timer.sv
module pwr_wake_timer #(
    parameter int WAKE_CYCLES = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic load_i,
    input  logic osc_ready_i,
    output logic done_o
);
    localparam int CW = $clog2(WAKE_CYCLES + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(WAKE_CYCLES);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = LOAD_VAL;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= LOAD_VAL;
        else         cnt_q <= cnt_d;
    end

    assign done_o = (cnt_q == '0) && osc_ready_i;

    AST_CNT_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_q == '0 && !load_i) |=> (cnt_q == '0)); // R1

    AST_LOAD_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> (cnt_q == LOAD_VAL)); // R7

endmodule

// File: rtl/pwr_wake_sel.sv
module pwr_wake_sel #(
    parameter int NIRQ = 8
) (
    input  logic [NIRQ-1:0] irq_i,
    input  logic [NIRQ-1:0] irq_en_i,
    input  logic [NIRQ-1:0] sleep_mask_i,
    output logic            idle_wake_o,
    output logic            sleep_wake_o
);
    logic [NIRQ-1:0] idle_hit, sleep_hit;

    for (genvar g = 0; g < NIRQ; g++) begin : g_line
        assign idle_hit[g]  = irq_i[g] & irq_en_i[g];
        assign sleep_hit[g] = irq_i[g] & sleep_mask_i[g];
    end

    assign idle_wake_o  = |idle_hit;
    assign sleep_wake_o = |sleep_hit;

endmodule

// File: rtl/pwr_clk_map.sv
module pwr_clk_map
    import pwr_seq_pkg::*;
(
    input  pwr_state_e state_i,
    output clk_ctl_t   ctl_o
);
    always_comb begin
        ctl_o = '0;
        unique case (state_i)
            ST_WARM: begin
                ctl_o.osc     = 1'b1;
                ctl_o.irc_out = 1'b1;
                ctl_o.div_rst = 1'b1;
            end
            ST_RUN: begin
                ctl_o.cpu     = 1'b1;
                ctl_o.periph  = 1'b1;
                ctl_o.osc     = 1'b1;
                ctl_o.irc_out = 1'b1;
            end
            ST_IDLE: begin
                ctl_o.periph  = 1'b1;
                ctl_o.osc     = 1'b1;
                ctl_o.irc_out = 1'b1;
            end
            ST_SLEEP: begin
                ctl_o.div_rst = 1'b1;
            end
            default: ctl_o = '0;
        endcase
    end

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
    import pwr_seq_pkg::*;
#(
    parameter int NIRQ        = 8,
    parameter int WAKE_CYCLES = 16
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            req_wr_i,
    input  logic [1:0]      req_mode_i,
    input  logic            cfg_wr_i,
    input  logic            cfg_pll_en_i,
    input  logic            cfg_pll_conn_i,
    input  logic [NIRQ-1:0] irq_i,
    input  logic [NIRQ-1:0] irq_en_i,
    input  logic [NIRQ-1:0] sleep_wake_mask_i,
    input  logic            osc_ready_i,
    output logic            cpu_clk_en_o,
    output logic            periph_clk_en_o,
    output logic            main_osc_en_o,
    output logic            irc_out_en_o,
    output logic            irc_pwr_en_o,
    output logic            rtc_osc_en_o,
    output logic            flash_en_o,
    output logic            pll_en_o,
    output logic            pll_connect_o,
    output logic            div_rst_o,
    output logic [1:0]      mode_o,
    output logic [1:0]      exit_mode_o
);
    localparam pwr_ctx_t CTX_RST = '{state: ST_WARM, mode: MODE_RUN,
                                     exited: MODE_RUN, pll_en: 1'b0,
                                     pll_conn: 1'b0};

    pwr_ctx_t ctx_d, ctx_q;
    logic     load_d;
    logic     timer_done, idle_wake, sleep_wake;
    clk_ctl_t ctl;

    pwr_wake_timer #(.WAKE_CYCLES(WAKE_CYCLES)) u_timer (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .load_i      (load_d),
        .osc_ready_i (osc_ready_i),
        .done_o      (timer_done)
    );

    pwr_wake_sel #(.NIRQ(NIRQ)) u_wake (
        .irq_i        (irq_i),
        .irq_en_i     (irq_en_i),
        .sleep_mask_i (sleep_wake_mask_i),
        .idle_wake_o  (idle_wake),
        .sleep_wake_o (sleep_wake)
    );

    pwr_clk_map u_map (
        .state_i (ctx_q.state),
        .ctl_o   (ctl)
    );

    always_comb begin
        ctx_d  = ctx_q;
        load_d = 1'b0;
        unique case (ctx_q.state)
            ST_WARM: begin
                if (timer_done) ctx_d.state = ST_RUN;
            end
            ST_RUN: begin
                if (cfg_wr_i) begin
                    ctx_d.pll_en   = cfg_pll_en_i;
                    ctx_d.pll_conn = cfg_pll_en_i & cfg_pll_conn_i;
                end
                if (req_wr_i && req_mode_i == MODE_IDLE) begin
                    ctx_d.state = ST_IDLE;
                    ctx_d.mode  = MODE_IDLE;
                end else if (req_wr_i && req_mode_i == MODE_SLEEP) begin
                    ctx_d.state    = ST_SLEEP;
                    ctx_d.mode     = MODE_SLEEP;
                    ctx_d.pll_en   = 1'b0;
                    ctx_d.pll_conn = 1'b0;
                end
            end
            ST_IDLE: begin
                if (idle_wake) begin
                    ctx_d.state  = ST_RUN;
                    ctx_d.mode   = MODE_RUN;
                    ctx_d.exited = MODE_IDLE;
                end
            end
            ST_SLEEP: begin
                if (sleep_wake) begin
                    ctx_d.state  = ST_WARM;
                    ctx_d.mode   = MODE_RUN;
                    ctx_d.exited = MODE_SLEEP;
                    load_d       = 1'b1;
                end
            end
            default: ctx_d = CTX_RST;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ctx_q <= CTX_RST;
        else         ctx_q <= ctx_d;
    end

    assign cpu_clk_en_o    = ctl.cpu;
    assign periph_clk_en_o = ctl.periph;
    assign main_osc_en_o   = ctl.osc;
    assign irc_out_en_o    = ctl.irc_out;
    assign div_rst_o       = ctl.div_rst;
    assign irc_pwr_en_o    = 1'b1;
    assign rtc_osc_en_o    = 1'b1;
    assign flash_en_o      = 1'b1;
    assign pll_en_o        = ctx_q.pll_en;
    assign pll_connect_o   = ctx_q.pll_conn;
    assign mode_o          = ctx_q.mode;
    assign exit_mode_o     = ctx_q.exited;

    AST_RUN_AFTER_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctx_q.state == ST_RUN && $past(ctx_q.state) == ST_WARM) |-> $past(osc_ready_i)); // R1

    AST_IDLE_WAKE_DIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctx_q.state == ST_IDLE && idle_wake) |=> (cpu_clk_en_o && mode_o == MODE_RUN)); // R4

    AST_SLEEP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctx_q.state == ST_SLEEP) |-> (!main_osc_en_o && !pll_en_o && !pll_connect_o && !cpu_clk_en_o)); // R5

    AST_SLEEP_EXIT_TIMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctx_q.state == ST_SLEEP) |=> !cpu_clk_en_o); // R7

    AST_WARM_MODE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctx_q.state == ST_WARM) |-> (mode_o == MODE_RUN)); // R10

    AST_IDLE_HOLD_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctx_q.state == ST_IDLE && !idle_wake) |=> (ctx_q.state == ST_IDLE)); // R8

endmodule

// File: tb/pwr_seq_ctrl_bench.sv
module pwr_seq_ctrl_bench;
    localparam int NIRQ = 8;
    localparam int W    = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_wr = 1'b0;
    logic [1:0]      req_mode = 2'b00;
    logic            cfg_wr = 1'b0;
    logic            cfg_en = 1'b0;
    logic            cfg_conn = 1'b0;
    logic [NIRQ-1:0] irq = '0;
    logic [NIRQ-1:0] irq_en = 8'h0F;
    logic [NIRQ-1:0] smask = 8'h10;
    logic            osc_rdy = 1'b0;
    logic cpu, per, osc, irc_out, irc_pwr, rtc, flash, pll_en, pll_conn, div_rst;
    logic [1:0] mode, exitm;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    pwr_seq_ctrl #(.NIRQ(NIRQ), .WAKE_CYCLES(W)) u_pwr_seq_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .req_wr_i(req_wr), .req_mode_i(req_mode),
        .cfg_wr_i(cfg_wr), .cfg_pll_en_i(cfg_en), .cfg_pll_conn_i(cfg_conn),
        .irq_i(irq), .irq_en_i(irq_en), .sleep_wake_mask_i(smask),
        .osc_ready_i(osc_rdy), .cpu_clk_en_o(cpu), .periph_clk_en_o(per),
        .main_osc_en_o(osc), .irc_out_en_o(irc_out), .irc_pwr_en_o(irc_pwr),
        .rtc_osc_en_o(rtc), .flash_en_o(flash), .pll_en_o(pll_en),
        .pll_connect_o(pll_conn), .div_rst_o(div_rst), .mode_o(mode),
        .exit_mode_o(exitm)
    );

    typedef struct packed {
        logic [7:0]      rq;
        logic            wr;
        logic [1:0]      md;
        logic [NIRQ-1:0] irq;
        logic [4:0]      exp;   // {cpu, periph, osc, mode}
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{8'd3, 1'b1, 2'b01, 8'h00, 5'b011_01},  // R3 enter idle
        '{8'd8, 1'b1, 2'b10, 8'h00, 5'b011_01},  // R8 request in idle ignored
        '{8'd4, 1'b0, 2'b00, 8'h80, 5'b011_01},  // R4 disabled irq ignored
        '{8'd4, 1'b0, 2'b00, 8'h01, 5'b111_00},  // R4 enabled irq wakes
        '{8'd8, 1'b1, 2'b11, 8'h00, 5'b111_00},  // R8 code 11 ignored
        '{8'd2, 1'b1, 2'b00, 8'h00, 5'b111_00},  // R2 run request keeps run
        '{8'd3, 1'b1, 2'b01, 8'h00, 5'b011_01},  // R3 idle again
        '{8'd10, 1'b0, 2'b00, 8'h02, 5'b111_00}, // R10 mode clears on wake
        '{8'd5, 1'b1, 2'b10, 8'h00, 5'b000_10},  // R5 enter sleep
        '{8'd6, 1'b0, 2'b00, 8'h01, 5'b000_10}   // R6 idle-only irq ignored
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic count_to_cpu(output int n);
        n = 0;
        while (!cpu && n < 200) begin
            step();
            n++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int n;
        // R1 / R9 reset state
        repeat (3) step();
        chk("R1 reset cpu", {31'd0, cpu}, 32'd0);
        chk("R9 reset mode/exit", {28'd0, mode, exitm}, 32'd0);
        rst_n = 1'b1;
        repeat (W + 4) step();
        chk("R1 held without osc ready", {31'd0, cpu}, 32'd0);
        chk("R1 osc on during warm-up", {31'd0, osc}, 32'd1);
        osc_rdy = 1'b1;
        step();
        chk("R1 release on ready", {31'd0, cpu}, 32'd1);
        chk("R2 run enables", {28'd0, cpu, per, osc, irc_out}, 32'hF);
        chk("R2 run mode", {30'd0, mode}, 32'd0);

        // R11 PLL configuration
        cfg_wr = 1'b1; cfg_en = 1'b0; cfg_conn = 1'b1;
        step();
        chk("R11 connect needs power", {30'd0, pll_en, pll_conn}, 32'd0);
        cfg_en = 1'b1;
        step();
        cfg_wr = 1'b0;
        chk("R11 pll set", {30'd0, pll_en, pll_conn}, 32'd3);

        // table walk
        for (int i = 0; i < NV; i++) begin
            req_wr = VECS[i].wr; req_mode = VECS[i].md; irq = VECS[i].irq;
            step();
            req_wr = 1'b0; req_mode = 2'b00; irq = '0;
            chk($sformatf("R%0d vector %0d", VECS[i].rq, i),
                {27'd0, cpu, per, osc, mode}, {27'd0, VECS[i].exp});
            if (i == 3) chk("R4 exit mode idle", {30'd0, exitm}, 32'd1);
        end

        // in sleep now
        chk("R5 sleep side signals",
            {25'd0, irc_out, irc_pwr, rtc, flash, pll_en, pll_conn, div_rst},
            32'b0111001);
        cfg_wr = 1'b1; cfg_en = 1'b1; cfg_conn = 1'b1;
        step();
        cfg_wr = 1'b0;
        chk("R8 config ignored in sleep", {30'd0, pll_en, pll_conn}, 32'd0);

        // R7 sleep wake
        irq = 8'h10;
        step();
        irq = '0;
        chk("R7 warm after wake", {29'd0, cpu, osc, div_rst}, 32'b011);
        chk("R7 exit mode sleep", {30'd0, exitm}, 32'd2);
        chk("R10 mode cleared", {30'd0, mode}, 32'd0);
        count_to_cpu(n);
        chk("R7 wake count", n, W + 1);
        chk("R11 pll off after wake", {30'd0, pll_en, pll_conn}, 32'd0);

        // R9 reset from idle, exact count with ready high
        req_wr = 1'b1; req_mode = 2'b01;
        step();
        req_wr = 1'b0;
        chk("R3 idle before reset", {30'd0, mode}, 32'd1);
        rst_n = 1'b0;
        #1;
        chk("R9 reset leaves idle", {29'd0, cpu, mode}, 32'd0);
        step();
        rst_n = 1'b1;
        count_to_cpu(n);
        chk("R1 exact release count", n, W + 1);
        chk("R9 exit cleared", {30'd0, exitm}, 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule